// File: doc/BRIEF.md
# Alternate-Space Cache Control Register File

This block sits on the alternate-space load/store port of a processor and steers each access by its 8-bit address space identifier (ASI) and its address. It holds the cache control word, which sets the operating mode of the instruction and data caches, data snooping and instruction burst fill. It answers reads of two fixed configuration words, and it turns flush requests into single-cycle pulses toward the caches. Accesses for the MMU register set go straight to an MMU port. Normal and forced-miss data accesses are marked for the cache path, and the block does not answer them itself.

Every access that the block answers gets exactly one response, in the cycle after the request. That response carries read data and an error flag. ASIs and offsets that are not decoded give an error response, and they change no state. The caches, the MMU and memory are outside this block.

Top module: `asi_ctrl_regfile`

## Requirements
- R1: While reset is asserted and in the first cycles after release, `rsp_valid`, `rsp_err`, both flush pulses, `snoop_en` and `ifetch_burst_en` are low. Both caches report disabled (`*_on`=0, `*_fill`=0), and the control word reads back as zero.
- R2: A write with ASI 0x02 at offset 0x00 loads control bits 23 (snoop enable), 16 (instruction burst fill), 3:2 (data cache state) and 1:0 (instruction cache state). A later read of that offset returns those bits and zero in every other position. Every answered access gives `rsp_valid` high for exactly the one cycle after the request.
- R3: Writing 1 to control bit 22 (data flush) or bit 21 (instruction flush) raises `dc_flush` or `ic_flush` for one cycle, in the cycle after the write. Both bits always read back as zero. Back-to-back triggering writes give back-to-back pulses.
- R4: Any write with ASI 0x15 (instruction flush) or ASI 0x16 (data flush) pulses the matching flush output in the next cycle, whatever the offset or data. Reads of these ASIs return zero with no error and no pulse.
- R5: Reads with ASI 0x02 at offset 0x08 return parameter `ICFG_WORD`, and reads at offset 0x0C return `DCFG_WORD`. Writes to those offsets are answered without error, change nothing, and leave the control word as it was.
- R6: Each 2-bit cache state decodes as follows: 00 or 10 means disabled (`on`=0, `fill`=0), 01 means frozen (`on`=1, `fill`=0), 11 means enabled (`on`=1, `fill`=1).
- R7: `snoop_en` follows control bit 23 and `ifetch_burst_en` follows control bit 16, from the cycle after the write.
- R8: ASIs 0x08 to 0x0B raise `cache_req` in the same cycle with `cache_force_miss`=0. ASI 0x01 raises `cache_req` with `cache_force_miss`=1. Neither produces a response from this block.
- R9: ASI 0x19 at offsets 0x000, 0x100, 0x200, 0x300 and 0x400 raises `mmu_req` in the same cycle. It sets `mmu_idx` to offset/0x100, and `mmu_we` and `mmu_wdata` follow the request. A read returns, in the next cycle, the `mmu_rdata` value present during the request cycle.
- R10: An undecoded ASI, or an offset outside the map of ASI 0x02 or ASI 0x19, gives a response with `rsp_err`=1 and zero data for one cycle, and a write of that kind changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_asi | input | 8 | Address space identifier |
| req_addr | input | ADDR_W | Access address / register offset |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response from this block (one cycle) |
| rsp_err | output | 1 | Access was not decoded |
| rsp_rdata | output | 32 | Load data of the response |
| cache_req | output | 1 | Access belongs to the cache path |
| cache_force_miss | output | 1 | Cache path access must bypass hits |
| mmu_req | output | 1 | Access targets an MMU register |
| mmu_we | output | 1 | MMU register write |
| mmu_idx | output | MMU_IDX_W | MMU register index |
| mmu_wdata | output | 32 | MMU register write data |
| mmu_rdata | input | 32 | MMU register read data, same cycle |
| ic_flush | output | 1 | Instruction cache flush pulse |
| dc_flush | output | 1 | Data cache flush pulse |
| ic_on | output | 1 | Instruction cache active (frozen or enabled) |
| ic_fill | output | 1 | Instruction cache may allocate lines |
| dc_on | output | 1 | Data cache active (frozen or enabled) |
| dc_fill | output | 1 | Data cache may allocate lines |
| snoop_en | output | 1 | Data snooping enabled |
| ifetch_burst_en | output | 1 | Instruction burst fill enabled |

## Verification
The hardest cases to reach from the ports are the ones where a store must leave no trace. Examples are a store to a read-only configuration offset, a store to an undecoded ASI, and the flush bits, which act without being stored. Their only observable effect is on later reads. The stimulus therefore follows each such store with a load of the control word in the very next vector, so that any stray update shows up in the read data. Back-to-back flush stores, followed by an idle cycle, show that each pulse lasts exactly one cycle and is not stretched or merged.

// File: rtl/asi_ctl_pkg.sv
package asi_ctl_pkg;

  localparam logic [7:0] ASI_FORCE_MISS = 8'h01;
  localparam logic [7:0] ASI_SYSREG     = 8'h02;
  localparam logic [7:0] ASI_CACHED_LO  = 8'h08;
  localparam logic [7:0] ASI_CACHED_HI  = 8'h0B;
  localparam logic [7:0] ASI_IFLUSH     = 8'h15;
  localparam logic [7:0] ASI_DFLUSH     = 8'h16;
  localparam logic [7:0] ASI_MMU        = 8'h19;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_ICFG = 'h08;
  localparam int OFS_DCFG = 'h0C;

  localparam int CTL_SNOOP  = 23;
  localparam int CTL_DFLUSH = 22;
  localparam int CTL_IFLUSH = 21;
  localparam int CTL_IBURST = 16;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_ICFG,
    ACC_DCFG,
    ACC_MMU,
    ACC_CACHED,
    ACC_MISS,
    ACC_IFLUSH,
    ACC_DFLUSH,
    ACC_BAD
  } acc_kind_e;

  typedef struct packed {
    logic       snoop;
    logic       iburst;
    logic [1:0] dstate;
    logic [1:0] istate;
  } ctl_fields_t;

endpackage

// File: rtl/asi_route_decode.sv
module asi_route_decode
  import asi_ctl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MMU_REGS   = 5,
  parameter int MMU_STRIDE = 8,
  localparam int MMU_IDX_W = $clog2(MMU_REGS)
) (
  input  logic                 valid,
  input  logic [7:0]           asi,
  input  logic [ADDR_W-1:0]    addr,
  output acc_kind_e            kind,
  output logic [MMU_IDX_W-1:0] mmu_idx
);

  localparam int IDX_TOP = MMU_STRIDE + MMU_IDX_W;

  logic mmu_low_zero;
  logic mmu_high_zero;
  logic mmu_in_range;
  logic mmu_ofs_ok;

  assign mmu_idx       = addr[MMU_STRIDE +: MMU_IDX_W];
  assign mmu_low_zero  = (addr[MMU_STRIDE-1:0] == '0);
  assign mmu_high_zero = ((addr >> IDX_TOP) == '0);
  assign mmu_in_range  = ({1'b0, mmu_idx} < (MMU_IDX_W+1)'(MMU_REGS));
  assign mmu_ofs_ok    = mmu_low_zero && mmu_high_zero && mmu_in_range;

  always_comb begin
    kind = ACC_NONE;
    if (valid) begin
      if (asi == ASI_SYSREG) begin
        if (addr == ADDR_W'(OFS_CTRL))      kind = ACC_CTRL;
        else if (addr == ADDR_W'(OFS_ICFG)) kind = ACC_ICFG;
        else if (addr == ADDR_W'(OFS_DCFG)) kind = ACC_DCFG;
        else                                kind = ACC_BAD;
      end else if (asi == ASI_MMU) begin
        kind = mmu_ofs_ok ? ACC_MMU : ACC_BAD;
      end else if (asi >= ASI_CACHED_LO && asi <= ASI_CACHED_HI) begin
        kind = ACC_CACHED;
      end else if (asi == ASI_FORCE_MISS) begin
        kind = ACC_MISS;
      end else if (asi == ASI_IFLUSH) begin
        kind = ACC_IFLUSH;
      end else if (asi == ASI_DFLUSH) begin
        kind = ACC_DFLUSH;
      end else begin
        kind = ACC_BAD;
      end
    end
  end

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import asi_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        any_wr,
  input  logic        ctl_wr,
  input  logic [31:0] wdata,
  input  logic        asi_iflush,
  input  logic        asi_dflush,
  output ctl_fields_t fields,
  output logic [31:0] ctl_word,
  output logic        ic_flush,
  output logic        dc_flush
);

  ctl_fields_t fields_q;
  ctl_fields_t fields_d;
  logic        ifl_q;
  logic        ifl_d;
  logic        dfl_q;
  logic        dfl_d;

  always_comb begin
    fields_d.snoop  = wdata[CTL_SNOOP];
    fields_d.iburst = wdata[CTL_IBURST];
    fields_d.dstate = wdata[3:2];
    fields_d.istate = wdata[1:0];
    ifl_d = (ctl_wr && wdata[CTL_IFLUSH]) || asi_iflush;
    dfl_d = (ctl_wr && wdata[CTL_DFLUSH]) || asi_dflush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
    end else if (ctl_wr) begin
      fields_q <= fields_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifl_q <= 1'b0;
      dfl_q <= 1'b0;
    end else begin
      ifl_q <= ifl_d;
      dfl_q <= dfl_d;
    end
  end

  assign fields   = fields_q;
  assign ic_flush = ifl_q;
  assign dc_flush = dfl_q;
  assign ctl_word = {8'h00, fields_q.snoop, 2'b00, 4'h0, fields_q.iburst,
                     12'h000, fields_q.dstate, fields_q.istate};

  // a flush pulse must trace back to a store in the previous cycle
  assert_iflush_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ic_flush |-> $past(any_wr));
  assert_dflush_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dc_flush |-> $past(any_wr));
  // control fields only move on a control write
  assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(fields_q));

endmodule

// File: rtl/cache_mode_decode.sv
module cache_mode_decode (
  input  logic [1:0] state,
  output logic       on,
  output logic       fill
);

  always_comb begin
    on   = 1'b0;
    fill = 1'b0;
    case (state)
      2'b01:   on = 1'b1;
      2'b11: begin
        on   = 1'b1;
        fill = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/asi_ctrl_regfile.sv
module asi_ctrl_regfile
  import asi_ctl_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          MMU_REGS   = 5,
  parameter int          MMU_STRIDE = 8,
  parameter logic [31:0] ICFG_WORD  = 32'h1322_0100,
  parameter logic [31:0] DCFG_WORD  = 32'h0B32_0108,
  localparam int         MMU_IDX_W  = $clog2(MMU_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [7:0]           req_asi,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [31:0]          rsp_rdata,
  output logic                 cache_req,
  output logic                 cache_force_miss,
  output logic                 mmu_req,
  output logic                 mmu_we,
  output logic [MMU_IDX_W-1:0] mmu_idx,
  output logic [31:0]          mmu_wdata,
  input  logic [31:0]          mmu_rdata,
  output logic                 ic_flush,
  output logic                 dc_flush,
  output logic                 ic_on,
  output logic                 ic_fill,
  output logic                 dc_on,
  output logic                 dc_fill,
  output logic                 snoop_en,
  output logic                 ifetch_burst_en
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  acc_kind_e   kind;
  ctl_fields_t fields;
  logic [31:0] ctl_word;
  logic        any_wr;
  logic        ctl_wr;
  logic        asi_ifl;
  logic        asi_dfl;

  asi_route_decode #(
    .ADDR_W    (ADDR_W),
    .MMU_REGS  (MMU_REGS),
    .MMU_STRIDE(MMU_STRIDE)
  ) u_dec (
    .valid  (req_valid),
    .asi    (req_asi),
    .addr   (req_addr),
    .kind   (kind),
    .mmu_idx(mmu_idx)
  );

  assign any_wr  = req_valid && req_write;
  assign ctl_wr  = any_wr && (kind == ACC_CTRL);
  assign asi_ifl = any_wr && (kind == ACC_IFLUSH);
  assign asi_dfl = any_wr && (kind == ACC_DFLUSH);

  ctl_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .any_wr    (any_wr),
    .ctl_wr    (ctl_wr),
    .wdata     (req_wdata),
    .asi_iflush(asi_ifl),
    .asi_dflush(asi_dfl),
    .fields    (fields),
    .ctl_word  (ctl_word),
    .ic_flush  (ic_flush),
    .dc_flush  (dc_flush)
  );

  cache_mode_decode u_imode (.state(fields.istate), .on(ic_on), .fill(ic_fill));
  cache_mode_decode u_dmode (.state(fields.dstate), .on(dc_on), .fill(dc_fill));

  assign snoop_en        = fields.snoop;
  assign ifetch_burst_en = fields.iburst;

  // pass-through routing toward the cache path and the MMU
  assign cache_req        = (kind == ACC_CACHED) || (kind == ACC_MISS);
  assign cache_force_miss = (kind == ACC_MISS);
  assign mmu_req          = (kind == ACC_MMU);
  assign mmu_we           = mmu_req && req_write;
  assign mmu_wdata        = req_wdata;

  // response register
  logic        rv_d;
  logic        rv_q;
  logic        err_d;
  logic        err_q;
  logic [31:0] rd_d;
  logic [31:0] rd_q;
  logic        rdctl_d;
  logic        rdctl_q;

  always_comb begin
    rv_d    = 1'b0;
    err_d   = 1'b0;
    rd_d    = '0;
    rdctl_d = 1'b0;
    case (kind)
      ACC_CTRL: begin
        rv_d    = 1'b1;
        rdctl_d = !req_write;
        if (!req_write) rd_d = ctl_word;
      end
      ACC_ICFG: begin
        rv_d = 1'b1;
        if (!req_write) rd_d = ICFG_WORD;
      end
      ACC_DCFG: begin
        rv_d = 1'b1;
        if (!req_write) rd_d = DCFG_WORD;
      end
      ACC_MMU: begin
        rv_d = 1'b1;
        if (!req_write) rd_d = mmu_rdata;
      end
      ACC_IFLUSH, ACC_DFLUSH: rv_d = 1'b1;
      ACC_BAD: begin
        rv_d  = 1'b1;
        err_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rv_q    <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= '0;
      rdctl_q <= 1'b0;
    end else begin
      rv_q    <= rv_d;
      err_q   <= err_d;
      rd_q    <= rd_d;
      rdctl_q <= rdctl_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rd_q;

  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));
  assert_bad_no_state_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && kind == ACC_BAD) |=> $stable(ctl_word));
  assert_route_excl_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({cache_req, mmu_req}));
  assert_cache_silent_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cache_req |=> !rsp_valid);
  assert_mmu_read_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mmu_req && !mmu_we) |=> (rsp_valid && rsp_rdata == $past(mmu_rdata)));
  assert_flushbits_zero_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdctl_q |-> (rsp_rdata[CTL_DFLUSH:CTL_IFLUSH] == 2'b00));
  assert_cfg_readonly_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && (kind == ACC_ICFG || kind == ACC_DCFG)) |=> $stable(ctl_word));
  assert_ifill_on_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ic_fill |-> ic_on);
  assert_dfill_on_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dc_fill |-> dc_on);

endmodule

// File: tb/sim_asi_ctrl_regfile.sv
module sim_asi_ctrl_regfile;

  localparam int          CLK_PERIOD = 10;
  localparam int          Q          = CLK_PERIOD / 4;
  localparam logic [31:0] ICFG       = 32'hA5A5_0001;
  localparam logic [31:0] DCFG       = 32'h5A5A_0002;
  localparam int          NVEC       = 20;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [7:0]  asi;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] mrd;
    logic        erv;
    logic        eer;
    logic [31:0] erd;
    logic        eif;
    logic        edf;
    logic        ecr;
    logic        efm;
    logic        emr;
    logic [2:0]  eidx;
  } vec_t;

  // req, wr, asi, addr, wdata, mmu_rdata, rsp_valid, err, rdata, iflush, dflush, cache, miss, mmu, idx
  localparam vec_t VEC [NVEC] = '{
    '{4'd2,  1'b1, 8'h02, 12'h000, 32'h0081_000F, 32'h0, 1'b1, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 write
    '{4'd2,  1'b0, 8'h02, 12'h000, 32'h0,         32'h0, 1'b1, 1'b0, 32'h0081_000F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 read
    '{4'd3,  1'b1, 8'h02, 12'h000, 32'h0060_0005, 32'h0, 1'b1, 1'b0, 32'h0,          1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 flush bits
    '{4'd3,  1'b0, 8'h02, 12'h000, 32'h0,         32'h0, 1'b1, 1'b0, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 read zero
    '{4'd4,  1'b1, 8'h15, 12'h123, 32'h0,         32'h0, 1'b1, 1'b0, 32'h0,          1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R4 iflush asi
    '{4'd4,  1'b1, 8'h16, 12'hFFC, 32'hDEAD_BEEF, 32'h0, 1'b1, 1'b0, 32'h0,          1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R4 dflush asi
    '{4'd4,  1'b0, 8'h15, 12'h000, 32'h0,         32'h0, 1'b1, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R4 read no pulse
    '{4'd5,  1'b0, 8'h02, 12'h008, 32'h0,         32'h0, 1'b1, 1'b0, ICFG,           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R5 icfg
    '{4'd5,  1'b0, 8'h02, 12'h00C, 32'h0,         32'h0, 1'b1, 1'b0, DCFG,           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R5 dcfg
    '{4'd5,  1'b1, 8'h02, 12'h008, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R5 write ignored
    '{4'd5,  1'b0, 8'h02, 12'h000, 32'h0,         32'h0, 1'b1, 1'b0, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R5 ctl unchanged
    '{4'd8,  1'b0, 8'h0A, 12'h040, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0,          1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R8 cached read
    '{4'd8,  1'b1, 8'h08, 12'h044, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 32'h0,          1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R8 cached write
    '{4'd8,  1'b0, 8'h01, 12'h048, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0,          1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}, // R8 forced miss
    '{4'd9,  1'b0, 8'h19, 12'h200, 32'h0, 32'hCAFE_0001, 1'b1, 1'b0, 32'hCAFE_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}, // R9 mmu read
    '{4'd9,  1'b1, 8'h19, 12'h400, 32'h0000_00AB, 32'h0, 1'b1, 1'b0, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4}, // R9 mmu write
    '{4'd10, 1'b0, 8'h19, 12'h500, 32'h0, 32'h1111_1111, 1'b1, 1'b1, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5}, // R10 mmu gap
    '{4'd10, 1'b0, 8'h02, 12'h004, 32'h0,         32'h0, 1'b1, 1'b1, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R10 sysreg gap
    '{4'd10, 1'b1, 8'h33, 12'h000, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R10 bad asi
    '{4'd10, 1'b0, 8'h02, 12'h000, 32'h0,         32'h0, 1'b1, 1'b0, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}  // R10 no effect
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_asi;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        cache_req;
  logic        cache_force_miss;
  logic        mmu_req;
  logic        mmu_we;
  logic [2:0]  mmu_idx;
  logic [31:0] mmu_wdata;
  logic [31:0] mmu_rdata;
  logic        ic_flush;
  logic        dc_flush;
  logic        ic_on;
  logic        ic_fill;
  logic        dc_on;
  logic        dc_fill;
  logic        snoop_en;
  logic        ifetch_burst_en;

  int  checks;
  int  failures;
  bit  done;

  asi_ctrl_regfile #(
    .ICFG_WORD(ICFG),
    .DCFG_WORD(DCFG)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_asi(req_asi),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cache_req(cache_req), .cache_force_miss(cache_force_miss),
    .mmu_req(mmu_req), .mmu_we(mmu_we), .mmu_idx(mmu_idx),
    .mmu_wdata(mmu_wdata), .mmu_rdata(mmu_rdata),
    .ic_flush(ic_flush), .dc_flush(dc_flush),
    .ic_on(ic_on), .ic_fill(ic_fill), .dc_on(dc_on), .dc_fill(dc_fill),
    .snoop_en(snoop_en), .ifetch_burst_en(ifetch_burst_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [7:0] asi, input logic [31:0] addr,
                       input logic [31:0] wd, input logic [31:0] mrd);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_asi   = asi;
    req_addr  = addr;
    req_wdata = wd;
    mmu_rdata = mrd;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    req_asi   = 8'h00;
    req_addr  = '0;
    req_wdata = '0;
    mmu_rdata = '0;
  endtask

  task automatic past_edge();
    @(posedge clk);
    #(Q);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_asi = '0;
    req_addr = '0; req_wdata = '0; mmu_rdata = '0;
    repeat (3) @(posedge clk);
    #(Q);
    // R1 state during reset
    check(1, "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    check(1, "flush in reset", 32'({ic_flush, dc_flush}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #(Q);
    // R1 after release
    check(1, "modes after reset", 32'({ic_on, ic_fill, dc_on, dc_fill}), 32'h0);
    check(1, "snoop/burst after reset", 32'({snoop_en, ifetch_burst_en}), 32'h0);
    check(1, "rsp after reset", 32'({rsp_valid, rsp_err}), 32'h0);
    drive(1'b0, 8'h02, 32'h0, 32'h0, 32'h0);
    past_edge();
    check(1, "ctl word reset read", rsp_rdata, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].wr, VEC[i].asi, {20'h0, VEC[i].addr}, VEC[i].wd, VEC[i].mrd);
      #(Q);
      check(int'(VEC[i].req), $sformatf("v%0d cache_req", i), 32'(cache_req), 32'(VEC[i].ecr));
      check(int'(VEC[i].req), $sformatf("v%0d force_miss", i), 32'(cache_force_miss), 32'(VEC[i].efm));
      check(int'(VEC[i].req), $sformatf("v%0d mmu_req", i), 32'(mmu_req), 32'(VEC[i].emr));
      if (VEC[i].emr) begin
        check(9, $sformatf("v%0d mmu_idx", i), 32'(mmu_idx), 32'(VEC[i].eidx));
        check(9, $sformatf("v%0d mmu_we", i), 32'(mmu_we), 32'(VEC[i].wr));
        check(9, $sformatf("v%0d mmu_wdata", i), mmu_wdata, VEC[i].wd);
      end
      past_edge();
      check(int'(VEC[i].req), $sformatf("v%0d rsp_valid", i), 32'(rsp_valid), 32'(VEC[i].erv));
      check(int'(VEC[i].req), $sformatf("v%0d rsp_err", i), 32'(rsp_err), 32'(VEC[i].eer));
      if (VEC[i].erv)
        check(int'(VEC[i].req), $sformatf("v%0d rsp_rdata", i), rsp_rdata, VEC[i].erd);
      check(int'(VEC[i].req), $sformatf("v%0d ic_flush", i), 32'(ic_flush), 32'(VEC[i].eif));
      check(int'(VEC[i].req), $sformatf("v%0d dc_flush", i), 32'(dc_flush), 32'(VEC[i].edf));
    end
    idle();
    past_edge();
    // R10 error lasts one cycle; R2 response lasts one cycle
    check(10, "err dropped after idle", 32'({rsp_valid, rsp_err}), 32'h0);

    // R6 every state code for both caches
    for (int s = 0; s < 4; s++) begin
      drive(1'b1, 8'h02, 32'h0, 32'((s << 2) | (3 - s)), 32'h0);
      past_edge();
      check(6, $sformatf("dstate %0d on", s), 32'(dc_on), 32'(s == 1 || s == 3));
      check(6, $sformatf("dstate %0d fill", s), 32'(dc_fill), 32'(s == 3));
      check(6, $sformatf("istate %0d on", 3 - s), 32'(ic_on), 32'(s == 0 || s == 2));
      check(6, $sformatf("istate %0d fill", 3 - s), 32'(ic_fill), 32'(s == 0));
    end

    // R7 snoop and burst enables
    drive(1'b1, 8'h02, 32'h0, 32'h0080_0000, 32'h0);
    past_edge();
    check(7, "snoop only", 32'({snoop_en, ifetch_burst_en}), 32'h2);
    drive(1'b1, 8'h02, 32'h0, 32'h0001_0000, 32'h0);
    past_edge();
    check(7, "burst only", 32'({snoop_en, ifetch_burst_en}), 32'h1);

    // R3 back-to-back triggering writes, then a quiet cycle
    drive(1'b1, 8'h02, 32'h0, 32'h0020_0000, 32'h0);
    past_edge();
    check(3, "first ic pulse", 32'({ic_flush, dc_flush}), 32'h2);
    drive(1'b1, 8'h15, 32'h0, 32'h0, 32'h0);
    past_edge();
    check(3, "second ic pulse", 32'({ic_flush, dc_flush}), 32'h2);
    idle();
    past_edge();
    check(3, "pulse ends", 32'({ic_flush, dc_flush}), 32'h0);
    drive(1'b1, 8'h02, 32'h0, 32'h0040_0000, 32'h0);
    past_edge();
    check(3, "dc pulse from bit", 32'({ic_flush, dc_flush}), 32'h1);
    idle();
    past_edge();
    check(3, "dc pulse ends", 32'(dc_flush), 32'h0);

    finish_run();
  end

endmodule